// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer

This block produces the external bus activity of a small 8-bit processor core, one T-state per clock period. A controller asks for a single machine cycle by giving a kind code, an address and (for writes) a data byte. The block then walks through the T-states of that cycle. It drives the address, an address-latch pulse, the read, write and interrupt-acknowledge strobes, and the I/O-versus-memory select. When the ready input is held low, it stretches the cycle with wait T-states. On the final T-state of every cycle it raises a one-clock done flag, and the byte read during the cycle is held for the controller.

An opcode fetch takes four T-states; the fourth leaves the bus quiet so that the core can decode. All other kinds take three T-states. Interrupt acknowledge follows read timing but pulses its own strobe, and the byte it returns is marked as an opcode. A new cycle may begin in the T-state right after the previous one ends, so cycles can run back to back.

A built-in chain runs the whole bus side of an output-port instruction. It performs an opcode fetch at the program counter, reads the port byte from the next address, and then writes the accumulator to that port. The three cycles run back to back.

Top module: `mcyc_bus_seq`

## Requirements
- R1: An opcode fetch (kind code 0) lasts T1, T2, T3, T4 when ready stays high. `cyc_done` is high only in T4. Wait T-states are added between T2 and T3.
- R2: Memory read (1), memory write (2), I/O read (3), I/O write (4) and interrupt acknowledge (5) each last T1, T2, T3 when ready stays high. `cyc_done` is high only in T3.
- R3: `bus_ale` is high in T1 only. `bus_addr` carries the cycle address from T1 to the last T-state and is zero when idle.
- R4: `bus_rd_n` is low in T2, in wait states and in T3 of kinds 0, 1 and 3. `bus_wr_n` is low in the same T-states of kinds 2 and 4. `bus_inta_n` is low in the same T-states of kind 5. No strobe is low in T1, in T4 or when idle, and at most one is low at a time.
- R5: `bus_io_m` is 1 for kinds 3, 4 and 5 and 0 for kinds 0, 1 and 2. It is held through every T-state of the cycle and is 0 when idle.
- R6: `ready` is sampled at the end of T2 and at the end of each wait state. While it is low, wait T-states follow, the strobe stays low, and the cycle lasts its nominal length plus the number of waits.
- R7: At the end of T3 of kinds 0, 1, 3 and 5, `bus_din` is stored in `rdata`. `rdata_is_op` is set for kinds 0 and 5 and cleared for kinds 1 and 3. Write cycles leave both unchanged.
- R8: In write cycles, `bus_dout_en` is high from T2 through T3, including waits, with `bus_dout` equal to the request data. Otherwise `bus_dout_en` is low.
- R9: A request is taken when the block is idle or in the last T-state of a cycle, and its T1 comes in the next clock period. Kind codes 6 and 7 are ignored and start nothing.
- R10: A pulse on `out_start` runs three cycles back to back: an opcode fetch at `out_pc`, a memory read at `out_pc`+1, and an I/O write of `out_acc` to the address made of the byte just read, placed in both the upper and lower halves. This is 10 T-states without waits. `seq_done` is high on the final T-state, and `out_start` wins over a same-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Single machine-cycle request |
| req_kind | input | 3 | Cycle kind code (0..5) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data for write kinds |
| out_start | input | 1 | Start the output-port instruction chain |
| out_pc | input | 16 | Address of the chain's opcode byte |
| out_acc | input | 8 | Data written to the port by the chain |
| ready | input | 1 | High when the addressed device can finish |
| bus_din | input | 8 | Data bus input |
| bus_addr | output | 16 | Address bus |
| bus_ale | output | 1 | Address latch pulse |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| bus_io_m | output | 1 | 1 selects I/O, 0 selects memory |
| bus_dout | output | 8 | Data bus output |
| bus_dout_en | output | 1 | Data bus output enable |
| busy | output | 1 | A machine cycle is in progress |
| cyc_done | output | 1 | Last T-state of the current cycle |
| seq_done | output | 1 | Last T-state of the chained sequence |
| rdata | output | 8 | Last byte read |
| rdata_is_op | output | 1 | Last byte read is an opcode |

## Verification
The assertions check the following on every cycle:
- T1 is always followed by T2.
- A low ready at T2 or in a wait state always leads to a wait state, and a strobe is held low through every wait state.
- The T3 of a fetch leads to T4.
- The latch pulse lasts a single T-state, and no strobe is low while it is high.
- Address and select stay fixed within a cycle.
- At most one strobe is low at a time.
- Read data is taken at the end of T3.

Only the bench's scenarios can show that each kind code picks the right strobe and select level, that wait counts add exactly to the cycle length, that cycles can follow each other without a gap, that the illegal codes are ignored, and that the chained sequence builds the port address from the byte it read.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [2:0] {
        K_OPF  = 3'd0,
        K_MRD  = 3'd1,
        K_MWR  = 3'd2,
        K_IORD = 3'd3,
        K_IOWR = 3'd4,
        K_INTA = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_OPF  = 2'd1,
        CH_MRD  = 2'd2,
        CH_IOWR = 2'd3
    } chain_e;

    localparam logic [2:0] KIND_MAX = 3'd5;

    function automatic logic kind_reads(kind_e k);
        return (k == K_OPF) || (k == K_MRD) || (k == K_IORD) || (k == K_INTA);
    endfunction

    function automatic logic kind_writes(kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_io(kind_e k);
        return (k == K_IORD) || (k == K_IOWR) || (k == K_INTA);
    endfunction

    function automatic logic kind_is_opcode(kind_e k);
        return (k == K_OPF) || (k == K_INTA);
    endfunction

endpackage

// File: rtl/mcyc_tstate_fsm.sv
module mcyc_tstate_fsm
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  kind_e             start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] din,
    output phase_e            phase,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              last,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_op
);

    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rdata_op;
    } st_t;

    st_t st_d, st_q, load_st;

    always_comb begin
        load_st       = st_q;
        load_st.phase = PH_T1;
        load_st.kind  = start_kind;
        load_st.addr  = start_addr;
        load_st.wdata = start_wdata;

        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: if (start) st_d = load_st;
            PH_T1:   st_d.phase = PH_T2;
            PH_T2,
            PH_TW:   st_d.phase = ready ? PH_T3 : PH_TW;
            PH_T3: begin
                if (kind_reads(st_q.kind)) begin
                    load_st.rdata    = din;
                    load_st.rdata_op = kind_is_opcode(st_q.kind);
                    st_d.rdata       = din;
                    st_d.rdata_op    = kind_is_opcode(st_q.kind);
                end
                if (st_q.kind == K_OPF) st_d.phase = PH_T4;
                else if (start)         st_d = load_st;
                else                    st_d.phase = PH_IDLE;
            end
            PH_T4: begin
                if (start) st_d = load_st;
                else       st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase    = st_q.phase;
    assign kind     = st_q.kind;
    assign addr     = st_q.addr;
    assign wdata    = st_q.wdata;
    assign rdata    = st_q.rdata;
    assign rdata_op = st_q.rdata_op;
    assign last     = ((st_q.phase == PH_T3) && (st_q.kind != K_OPF)) || (st_q.phase == PH_T4);

    assert_t1_then_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2));
    assert_fetch_has_t4_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && kind == K_OPF) |=> (phase == PH_T4));
    assert_wait_inserted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T2 || phase == PH_TW) && !ready) |=> (phase == PH_TW));
    assert_capture_t3_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && kind_reads(kind)) |=> (rdata == $past(din)));

endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_inta_n,
    output logic              bus_io_m,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en
);

    logic in_cycle;
    logic strobe_window;

    always_comb begin
        in_cycle      = (phase != PH_IDLE);
        strobe_window = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);

        bus_addr    = in_cycle ? addr : '0;
        bus_ale     = (phase == PH_T1);
        bus_io_m    = in_cycle && kind_is_io(kind);
        bus_rd_n    = !(strobe_window && (kind == K_OPF || kind == K_MRD || kind == K_IORD));
        bus_wr_n    = !(strobe_window && kind_writes(kind));
        bus_inta_n  = !(strobe_window && (kind == K_INTA));
        bus_dout_en = strobe_window && kind_writes(kind);
        bus_dout    = bus_dout_en ? wdata : '0;
    end

endmodule

// File: rtl/mcyc_out_chain.sv
module mcyc_out_chain
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_start,
    input  logic [ADDR_W-1:0] out_pc,
    input  logic [DATA_W-1:0] out_acc,
    input  logic              can_accept,
    input  logic              last,
    input  logic [DATA_W-1:0] din,
    output logic              issue,
    output kind_e             issue_kind,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [DATA_W-1:0] issue_wdata,
    output logic              active,
    output logic              seq_done
);

    localparam int REP = ADDR_W / DATA_W;

    typedef struct packed {
        chain_e            st;
        logic [ADDR_W-1:0] nxt_addr;
        logic [DATA_W-1:0] acc;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d        = ch_q;
        issue       = 1'b0;
        issue_kind  = K_OPF;
        issue_addr  = '0;
        issue_wdata = '0;
        seq_done    = 1'b0;
        unique case (ch_q.st)
            CH_IDLE: if (out_start && can_accept) begin
                issue         = 1'b1;
                issue_kind    = K_OPF;
                issue_addr    = out_pc;
                ch_d.st       = CH_OPF;
                ch_d.nxt_addr = out_pc + ADDR_W'(1);
                ch_d.acc      = out_acc;
            end
            CH_OPF: if (last) begin
                issue      = 1'b1;
                issue_kind = K_MRD;
                issue_addr = ch_q.nxt_addr;
                ch_d.st    = CH_MRD;
            end
            CH_MRD: if (last) begin
                issue       = 1'b1;
                issue_kind  = K_IOWR;
                issue_addr  = {REP{din}};
                issue_wdata = ch_q.acc;
                ch_d.st     = CH_IOWR;
            end
            CH_IOWR: if (last) begin
                seq_done = 1'b1;
                ch_d.st  = CH_IDLE;
            end
            default: ch_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign active = (ch_q.st != CH_IDLE);

    assert_chain_step_on_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && issue) |-> last);

endmodule

// File: rtl/mcyc_bus_seq.sv
module mcyc_bus_seq
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              out_start,
    input  logic [ADDR_W-1:0] out_pc,
    input  logic [DATA_W-1:0] out_acc,
    input  logic              ready,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_inta_n,
    output logic              bus_io_m,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              busy,
    output logic              cyc_done,
    output logic              seq_done,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_is_op
);

    phase_e            fsm_phase;
    kind_e             fsm_kind;
    logic [ADDR_W-1:0] fsm_addr;
    logic [DATA_W-1:0] fsm_wdata;
    logic              fsm_last;
    logic              can_accept;
    logic              ext_take;
    logic              start;
    kind_e             start_kind;
    logic [ADDR_W-1:0] start_addr;
    logic [DATA_W-1:0] start_wdata;
    logic              ch_issue;
    kind_e             ch_kind;
    logic [ADDR_W-1:0] ch_addr;
    logic [DATA_W-1:0] ch_wdata;
    logic              ch_active;

    always_comb begin
        can_accept  = (fsm_phase == PH_IDLE) || fsm_last;
        ext_take    = req_valid && (req_kind <= KIND_MAX) && can_accept
                      && !ch_active && !out_start;
        start       = ch_issue || ext_take;
        start_kind  = ch_issue ? ch_kind  : kind_e'(req_kind);
        start_addr  = ch_issue ? ch_addr  : req_addr;
        start_wdata = ch_issue ? ch_wdata : req_wdata;
    end

    mcyc_out_chain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chain_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .out_start   (out_start),
        .out_pc      (out_pc),
        .out_acc     (out_acc),
        .can_accept  (can_accept),
        .last        (fsm_last),
        .din         (bus_din),
        .issue       (ch_issue),
        .issue_kind  (ch_kind),
        .issue_addr  (ch_addr),
        .issue_wdata (ch_wdata),
        .active      (ch_active),
        .seq_done    (seq_done)
    );

    mcyc_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_kind  (start_kind),
        .start_addr  (start_addr),
        .start_wdata (start_wdata),
        .ready       (ready),
        .din         (bus_din),
        .phase       (fsm_phase),
        .kind        (fsm_kind),
        .addr        (fsm_addr),
        .wdata       (fsm_wdata),
        .last        (fsm_last),
        .rdata       (rdata),
        .rdata_op    (rdata_is_op)
    );

    mcyc_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
        .phase       (fsm_phase),
        .kind        (fsm_kind),
        .addr        (fsm_addr),
        .wdata       (fsm_wdata),
        .bus_addr    (bus_addr),
        .bus_ale     (bus_ale),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_inta_n  (bus_inta_n),
        .bus_io_m    (bus_io_m),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en)
    );

    assign busy     = (fsm_phase != PH_IDLE);
    assign cyc_done = fsm_last;

    assert_ale_one_tstate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_done) |=> $stable(bus_addr));
    assert_no_strobe_in_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n && bus_inta_n));
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~bus_rd_n, ~bus_wr_n, ~bus_inta_n}));
    assert_select_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_done) |=> $stable(bus_io_m));
    assert_strobe_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_phase == PH_TW) |-> !(bus_rd_n && bus_wr_n && bus_inta_n));
    assert_seq_ends_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> cyc_done);

endmodule

// File: tb/mcyc_bus_seq_tb_top.sv
module mcyc_bus_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        ale;
        logic        rd_n;
        logic        wr_n;
        logic        inta_n;
        logic        io_m;
        logic        dout_en;
        logic [15:0] addr;
        logic [7:0]  dout;
        logic        done;
        logic        sdone;
        string       ltag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        out_start = 1'b0;
    logic [15:0] out_pc = 16'h0;
    logic [7:0]  out_acc = 8'h0;
    logic        ready = 1'b1;
    logic [7:0]  bus_din = 8'h0;
    logic [15:0] bus_addr;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_inta_n, bus_io_m;
    logic [7:0]  bus_dout;
    logic        bus_dout_en, busy, cyc_done, seq_done;
    logic [7:0]  rdata;
    logic        rdata_is_op;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    mon_en   = 1'b0;
    bit    finished = 1'b0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .out_start(out_start),
        .out_pc(out_pc), .out_acc(out_acc), .ready(ready), .bus_din(bus_din),
        .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_inta_n(bus_inta_n), .bus_io_m(bus_io_m),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .busy(busy),
        .cyc_done(cyc_done), .seq_done(seq_done), .rdata(rdata),
        .rdata_is_op(rdata_is_op)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected T-state items for one machine cycle (kind codes as in the brief)
    task automatic push_cycle(input int kind, input logic [15:0] addr, input logic [7:0] wd,
                              input int nwait, input bit last_sdone);
        item_t it;
        bit is_rd = (kind == 0 || kind == 1 || kind == 3);
        bit is_wr = (kind == 2 || kind == 4);
        bit is_ia = (kind == 5);
        bit io    = (kind == 3 || kind == 4 || kind == 5);
        string lt = (nwait > 0) ? "R6" : ((kind == 0) ? "R1" : "R2");
        it = '{ale:1'b1, rd_n:1'b1, wr_n:1'b1, inta_n:1'b1, io_m:io, dout_en:1'b0,
               addr:addr, dout:8'h0, done:1'b0, sdone:1'b0, ltag:lt};
        exp_q.push_back(it);
        for (int i = 0; i < nwait + 2; i++) begin
            it.ale = 1'b0; it.rd_n = !is_rd; it.wr_n = !is_wr; it.inta_n = !is_ia;
            it.dout_en = is_wr; it.dout = wd;
            it.done = (i == nwait + 1) && (kind != 0);
            it.sdone = it.done && last_sdone;
            exp_q.push_back(it);
        end
        if (kind == 0) begin
            it.rd_n = 1'b1; it.dout_en = 1'b0; it.done = 1'b1; it.sdone = last_sdone;
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_cycle(input int kind, input logic [15:0] addr, input logic [7:0] wd,
                             input int nwait, input logic [7:0] din);
        push_cycle(kind, addr, wd, nwait, 1'b0);
        bus_din = din;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = addr; req_wdata = wd; ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        ready = (nwait == 0);
        for (int w = 1; w <= nwait; w++) begin
            @(negedge clk);
            ready = (w == nwait);
        end
        wait_idle();
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && busy) begin
            if (exp_q.size() == 0) begin
                chk("R9", 32'(busy), 32'h0, "unexpected bus activity");
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk("R3", 32'(bus_ale), 32'(e.ale), "ale");
                chk("R3", 32'(bus_addr), 32'(e.addr), "addr");
                chk("R4", 32'({bus_rd_n, bus_wr_n, bus_inta_n}),
                    32'({e.rd_n, e.wr_n, e.inta_n}), "strobes rd/wr/inta");
                chk("R5", 32'(bus_io_m), 32'(e.io_m), "io_m");
                chk("R8", 32'(bus_dout_en), 32'(e.dout_en), "dout_en");
                if (e.dout_en) chk("R8", 32'(bus_dout), 32'(e.dout), "dout");
                chk(e.ltag, 32'(cyc_done), 32'(e.done), "cyc_done");
                chk("R10", 32'(seq_done), 32'(e.sdone), "seq_done");
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL R9 watchdog: actual hung expected idle");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3, R4, R5)
        chk("R3", 32'(bus_ale), 32'h0, "reset ale");
        chk("R3", 32'(bus_addr), 32'h0, "reset addr");
        chk("R4", 32'({bus_rd_n, bus_wr_n, bus_inta_n}), 32'h7, "reset strobes");
        chk("R5", 32'(bus_io_m), 32'h0, "reset io_m");
        chk("R9", 32'({busy, cyc_done, seq_done}), 32'h0, "reset busy/done");
        mon_en = 1'b1;

        run_cycle(1, 16'h1234, 8'h00, 0, 8'hA5);      // R2 memory read
        chk("R7", 32'({rdata_is_op, rdata}), 32'h0A5, "mem read data");
        run_cycle(0, 16'h0100, 8'h00, 0, 8'h3E);      // R1 fetch
        chk("R7", 32'({rdata_is_op, rdata}), 32'h13E, "fetch opcode");
        run_cycle(2, 16'h8000, 8'h5A, 0, 8'hEE);      // R8 memory write
        chk("R7", 32'({rdata_is_op, rdata}), 32'h13E, "write leaves rdata");
        run_cycle(3, 16'h4242, 8'h00, 2, 8'h77);      // R6 I/O read with 2 waits
        chk("R7", 32'({rdata_is_op, rdata}), 32'h077, "io read data");
        run_cycle(4, 16'h1111, 8'hC3, 1, 8'h00);      // R6/R8 I/O write with 1 wait
        run_cycle(5, 16'hABCD, 8'h00, 0, 8'hFF);      // R4 interrupt acknowledge
        chk("R7", 32'({rdata_is_op, rdata}), 32'h1FF, "inta opcode");
        run_cycle(0, 16'h0200, 8'h00, 3, 8'h21);      // R1/R6 fetch with 3 waits
        chk("R7", 32'({rdata_is_op, rdata}), 32'h121, "fetch after waits");

        // R9: illegal kind codes start nothing
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'hDEAD;
        @(negedge clk);
        chk("R9", 32'(busy), 32'h0, "kind 6 ignored");
        req_kind = 3'd7;
        @(negedge clk);
        chk("R9", 32'(busy), 32'h0, "kind 7 ignored");
        req_valid = 1'b0;

        // R9: back-to-back read then I/O read
        push_cycle(1, 16'h3000, 8'h00, 0, 1'b0);
        push_cycle(3, 16'h0909, 8'h00, 0, 1'b0);
        bus_din = 8'h11; ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h3000;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'h0909;
        @(negedge clk); req_valid = 1'b0; bus_din = 8'h22;
        wait_idle();
        chk("R9", 32'({rdata_is_op, rdata}), 32'h022, "back-to-back second data");

        // R10: output-port chain; a same-cycle request must lose
        push_cycle(0, 16'h2000, 8'h00, 0, 1'b0);
        push_cycle(1, 16'h2001, 8'h00, 0, 1'b0);
        push_cycle(4, 16'h5555, 8'h99, 0, 1'b1);
        bus_din = 8'h55;
        @(negedge clk);
        out_start = 1'b1; out_pc = 16'h2000; out_acc = 8'h99;
        req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h7777;
        @(negedge clk);
        out_start = 1'b0; req_valid = 1'b0;
        wait_idle();
        chk("R10", 32'({rdata_is_op, rdata}), 32'h055, "port byte read by chain");
        repeat (3) @(negedge clk);
        chk("R10", 32'(exp_q.size()), 32'h0, "all expected T-states seen");
        summary();
    end

endmodule